// File: doc/BRIEF.md
# Double-Pumped Wide SIMD Sequencer

This block executes 512-bit integer vector operations on a single 256-bit lane pipeline. When a wide operation is accepted, its lower 256-bit half enters the pipeline at once. The upper half waits in a staging register and enters the same pipeline on the following cycle. Both halves pass through the same fixed-latency lane stages. An output stage then joins them into one 512-bit result and returns it with the tag that came in with the operation.

Native 256-bit operations go straight through, using only the low halves of the operands. They can be freely mixed with wide operations. Per-half operations (add, and, xor) keep the native latency for each half. The fold operation needs both half results, so it adds a merge stage and finishes one cycle later than a wide per-half operation. Results leave in acceptance order, each as a single-cycle pulse on `out_valid`.

Top module: `dpsimd_seq`

## Requirements
- R1: An operation accepted with `in_wide` low uses only bits 255:0 of `in_a` and `in_b`. It produces its result on `out_data[255:0]`, with `out_data[511:256]` zero. `out_valid` is high in the cycle after the third rising edge that follows the acceptance edge (lane latency 3).
- R2: In the cycle after a wide operation is accepted, the upper half uses the pipeline and `in_ready` is low. After a narrow operation is accepted, `in_ready` is high in the next cycle.
- R3: A wide add, and or xor applies the operation to all 512 bits. It delivers the full 512-bit result one cycle after a narrow operation accepted on the same edge would have, i.e. 4 edges after acceptance.
- R4: A wide fold (op 3) returns the XOR of the two 256-bit half results in `out_data[255:0]`, with the upper 256 bits zero. It completes 5 edges after acceptance. `in_ready` also stays low in the second cycle after acceptance, leaving an empty slot for the merge.
- R5: Op encoding on `in_op`: 0 = independent 32-bit lane add modulo 2^32, 1 = bitwise and, 2 = bitwise xor, 3 = fold. A narrow fold returns the bitwise xor of the low operand halves.
- R6: `out_tag` equals the `in_tag` that was presented when the operation was accepted.
- R7: Every accepted operation yields exactly one `out_valid` pulse, in acceptance order, and no pulse appears without an accepted operation.
- R8: While `rst` is high on a rising edge, all in-flight operations and any pending upper half are discarded. After reset, `out_valid` is low and `in_ready` is high.
- R9: `in_valid` asserted while `in_ready` is low is ignored: no operation is taken and no result appears for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation slot free this cycle |
| in_op | input | 2 | Operation code (R5) |
| in_wide | input | 1 | 1 = 512-bit operation, 0 = 256-bit |
| in_tag | input | 4 | Tag returned with the result |
| in_a | input | 512 | First operand |
| in_b | input | 512 | Second operand |
| out_valid | output | 1 | Result pulse |
| out_tag | output | 4 | Tag of the result |
| out_data | output | 512 | Result value |

## Verification
The hardest case to reach from the ports is the merge cycle of a wide fold. In that cycle the merged result must be written out while the lane exit stays empty; only a narrow operation offered immediately after the fold can show a collision or a lost result. The bench therefore streams every op/width combination twice. In the first pass each operation is offered the moment the previous one is taken, so a narrow follows each wide fold as closely as the interface allows. In the second pass idle gaps separate the operations. The bench also fires a reset while an upper half is still pending and offers a decoy operation during a blocked upper-half slot.

// File: rtl/dpsimd_seq.sv
`timescale 1ns/1ps
module dpsimd_seq #(
  parameter int HALF_W = 256,
  parameter int LANE_W = 32,
  parameter int TAG_W  = 4,
  parameter int LAT    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_op,
  input  logic                  in_wide,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [2*HALF_W-1:0]   in_a,
  input  logic [2*HALF_W-1:0]   in_b,
  output logic                  out_valid,
  output logic [TAG_W-1:0]      out_tag,
  output logic [2*HALF_W-1:0]   out_data
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int NLANE  = HALF_W / LANE_W;
  localparam logic [1:0] OP_ADD = 2'd0, OP_AND = 2'd1, OP_FOLD = 2'd3;

  function automatic logic [HALF_W-1:0] lane_op(input logic [1:0] op,
                                                input logic [HALF_W-1:0] a,
                                                input logic [HALF_W-1:0] b);
    logic [HALF_W-1:0] s;
    for (int i = 0; i < NLANE; i++)
      s[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W];
    case (op)
      OP_ADD:  return s;
      OP_AND:  return a & b;
      default: return a ^ b;
    endcase
  endfunction

  // upper-half staging
  logic              hi_pend, gap;
  logic [HALF_W-1:0] hi_a, hi_b;
  logic [1:0]        hi_op;
  logic [TAG_W-1:0]  hi_tag;

  wire acc = in_valid && in_ready;
  assign in_ready = !hi_pend && !gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend <= 1'b0;
      gap     <= 1'b0;
    end else begin
      gap     <= hi_pend && (hi_op == OP_FOLD);
      hi_pend <= !hi_pend && acc && in_wide;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && in_wide) begin
      hi_a   <= in_a[FULL_W-1:HALF_W];
      hi_b   <= in_b[FULL_W-1:HALF_W];
      hi_op  <= in_op;
      hi_tag <= in_tag;
    end
  end

  // issue select
  wire [1:0]        sel_op  = hi_pend ? hi_op : in_op;
  wire [HALF_W-1:0] sel_a   = hi_pend ? hi_a  : in_a[HALF_W-1:0];
  wire [HALF_W-1:0] sel_b   = hi_pend ? hi_b  : in_b[HALF_W-1:0];
  wire              iss_v   = hi_pend || acc;
  wire              iss_w   = hi_pend || in_wide;
  wire [TAG_W-1:0]  iss_tag = hi_pend ? hi_tag : in_tag;

  // lane pipeline
  logic [LAT-1:0]    pv, ph, pw, pf;
  logic [TAG_W-1:0]  pt [LAT];
  logic [HALF_W-1:0] pd [LAT];

  always_ff @(posedge clk) begin
    if (rst) pv <= '0;
    else begin
      pv[0] <= iss_v;
      for (int i = 1; i < LAT; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    ph[0] <= hi_pend;
    pw[0] <= iss_w;
    pf[0] <= sel_op == OP_FOLD;
    pt[0] <= iss_tag;
    pd[0] <= lane_op(sel_op, sel_a, sel_b);
    for (int i = 1; i < LAT; i++) begin
      ph[i] <= ph[i-1];
      pw[i] <= pw[i-1];
      pf[i] <= pf[i-1];
      pt[i] <= pt[i-1];
      pd[i] <= pd[i-1];
    end
  end

  wire              ev = pv[LAT-1];
  wire              eh = ph[LAT-1];
  wire              ew = pw[LAT-1];
  wire              ef = pf[LAT-1];
  wire [TAG_W-1:0]  et = pt[LAT-1];
  wire [HALF_W-1:0] ed = pd[LAT-1];

  // merge and output
  logic              mrg_v;
  logic [HALF_W-1:0] lo_hold, mrg_d;
  logic [TAG_W-1:0]  mrg_tag;

  wire direct_done = ev && (!ew || (eh && !ef));
  wire fold_done   = ev && ew && eh && ef;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mrg_v     <= 1'b0;
    end else begin
      out_valid <= mrg_v || direct_done;
      mrg_v     <= fold_done;
    end
  end

  always_ff @(posedge clk) begin
    if (ev && ew && !eh) lo_hold <= ed;
    if (fold_done) begin
      mrg_d   <= lo_hold ^ ed;
      mrg_tag <= et;
    end
    if (mrg_v) begin
      out_data <= {{HALF_W{1'b0}}, mrg_d};
      out_tag  <= mrg_tag;
    end else if (direct_done) begin
      out_data <= ew ? {ed, lo_hold} : {{HALF_W{1'b0}}, ed};
      out_tag  <= et;
    end
  end

  p_upper_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && in_wide) |=> !in_ready);
  p_narrow_free_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_wide) |=> in_ready);
  p_fold_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && in_wide && in_op == OP_FOLD) |-> ##2 !in_ready);
  p_half_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (ev && ew && !eh) |=> (ev && ew && eh));
  p_merge_slot_r7: assert property (@(posedge clk) disable iff (rst)
    mrg_v |-> !ev);
  p_reset_clear_r8: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && in_ready));
endmodule

// File: tb/dpsimd_seq_bench.sv
`timescale 1ns/1ps
module dpsimd_seq_bench;
  localparam int HW = 256, FW = 512, TW = 4;

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic          in_valid = 0, in_wide = 0;
  logic          in_ready, out_valid;
  logic [1:0]    in_op = 0;
  logic [TW-1:0] in_tag = 0, out_tag;
  logic [FW-1:0] in_a = '0, in_b = '0, out_data;

  dpsimd_seq u_dpsimd_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_tag(in_tag), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data));

  int errors = 0, checks = 0, cyc = 0, block_until = -1;
  int head = 0, tail = 0;
  logic [TW-1:0] tag_ctr = 0;
  logic [FW-1:0] q_data [256];
  logic [TW-1:0] q_tag  [256];
  int            q_cyc  [256];
  int            q_kind [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] half_op(input logic [1:0] op, input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [HW-1:0] r;
    for (int i = 0; i < HW/32; i++) begin
      case (op)
        2'd0:    r[i*32 +: 32] = a[i*32 +: 32] + b[i*32 +: 32];
        2'd1:    r[i*32 +: 32] = a[i*32 +: 32] & b[i*32 +: 32];
        default: r[i*32 +: 32] = a[i*32 +: 32] ^ b[i*32 +: 32];
      endcase
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] model(input logic [1:0] op, input logic w, input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [HW-1:0] lo, hi;
    lo = half_op(op, a[HW-1:0], b[HW-1:0]);
    hi = half_op(op, a[FW-1:HW], b[FW-1:HW]);
    if (!w) return {{HW{1'b0}}, lo};
    if (op == 2'd3) return {{HW{1'b0}}, lo ^ hi};
    return {hi, lo};
  endfunction

  function automatic logic [FW-1:0] gen(input int p, input int s);
    logic [FW-1:0] v;
    for (int i = 0; i < FW/32; i++) begin
      case (p)
        0:       v[i*32 +: 32] = (s == 0) ? 32'hFFFF_FFFF : 32'h1;
        1:       v[i*32 +: 32] = ((i % 2 == s) ? 32'hAAAA_AAAA : 32'h5555_5555) ^ 32'(i);
        2:       v[i*32 +: 32] = 32'(i) * 32'h9E37_79B9 + 32'(s) * 32'h7F4A_7C15;
        default: v[i*32 +: 32] = {16'(i + 7 * s), 16'hC3A5 ^ 16'(s)};
      endcase
    end
    return v;
  endfunction

  function automatic string kind_req(input int k);
    return (k == 0) ? "R1 R5" : (k == 1) ? "R3 R5" : "R4 R5";
  endfunction

  // monitor: ready model, scoreboard, acceptance capture
  always @(negedge clk) begin
    if (!rst) begin
      if (cyc <= block_until)
        check(in_ready === 1'b0, "R2 R4 in_ready low in upper or merge slot", FW'(in_ready), FW'(0));
      else
        check(in_ready === 1'b1, "R2 in_ready high", FW'(in_ready), FW'(1));
      if (out_valid) begin
        if (head == tail)
          check(1'b0, "R7 R9 unexpected output", FW'(out_tag), '0);
        else begin
          check(out_data === q_data[head % 256], {kind_req(q_kind[head % 256]), " data"}, out_data, q_data[head % 256]);
          check(out_tag === q_tag[head % 256], "R6 tag", FW'(out_tag), FW'(q_tag[head % 256]));
          check(cyc == q_cyc[head % 256], {kind_req(q_kind[head % 256]), " latency"}, FW'(cyc), FW'(q_cyc[head % 256]));
          head++;
        end
      end else if (head != tail && cyc > q_cyc[head % 256]) begin
        check(1'b0, "R7 missing output", FW'(cyc), FW'(q_cyc[head % 256]));
        head++;
      end
      if (in_valid && in_ready) begin
        q_data[tail % 256] = model(in_op, in_wide, in_a, in_b);
        q_tag[tail % 256]  = in_tag;
        q_kind[tail % 256] = !in_wide ? 0 : (in_op == 2'd3) ? 2 : 1;
        q_cyc[tail % 256]  = cyc + 1 + (!in_wide ? 3 : (in_op == 2'd3) ? 5 : 4);
        tail++;
        if (in_wide) block_until = cyc + 1 + ((in_op == 2'd3) ? 1 : 0);
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic w, input logic [FW-1:0] a, input logic [FW-1:0] b);
    in_valid = 1; in_op = op; in_wide = w; in_a = a; in_b = b; in_tag = tag_ctr;
    tag_ctr++;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 out_valid after reset", FW'(out_valid), '0);
    check(in_ready === 1'b1, "R8 in_ready after reset", FW'(in_ready), FW'(1));
    @(posedge clk); #1;

    // sweep: back-to-back pass, then spaced pass
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 4; p++)
        for (int w = 0; w < 2; w++)
          for (int op = 0; op < 4; op++) begin
            send(2'(op), 1'(w), gen(p, 0), gen(p, 1));
            if (g == 1) idle(6);
          end
    idle(10);

    // mixed interleave around folds
    send(2'd0, 1'b0, gen(0, 0), gen(0, 1));
    send(2'd3, 1'b1, gen(2, 0), gen(2, 1));
    send(2'd2, 1'b0, gen(3, 0), gen(3, 1));
    send(2'd3, 1'b1, gen(1, 0), gen(3, 1));
    send(2'd3, 1'b1, gen(3, 0), gen(2, 1));
    send(2'd0, 1'b1, gen(0, 0), gen(0, 1));
    send(2'd1, 1'b0, gen(2, 0), gen(1, 1));
    idle(10);

    // R9: decoy offered during the blocked upper-half slot
    send(2'd1, 1'b1, gen(1, 0), gen(1, 1));
    in_valid = 1; in_op = 2'd0; in_wide = 1'b0; in_tag = 4'hF; in_a = gen(2, 0); in_b = gen(2, 1);
    @(posedge clk); #1;
    in_valid = 0;
    idle(10);
    check(head == tail, "R9 decoy not taken, queue drained", FW'(tail - head), '0);

    // R8: reset while an upper half is pending
    send(2'd3, 1'b1, gen(2, 0), gen(3, 1));
    rst = 1;
    idle(2);
    rst = 0;
    head = tail;
    block_until = -1;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      check(seen == 0, "R8 no output after reset flush", FW'(seen), '0);
    end
    check(in_ready === 1'b1, "R8 in_ready after flush", FW'(in_ready), FW'(1));
    @(posedge clk); #1;
    send(2'd0, 1'b1, gen(0, 0), gen(0, 1));
    idle(8);
    check(head == tail, "R7 all results delivered", FW'(tail - head), '0);

    summary();
    $finish;
  end
endmodule